// File: doc/BRIEF.md
# Interval Timer with Compare Interrupt

This block is the interval timer that sits beside one processor core. A free-running cycle counter advances by one on every clock. A 32-bit compare register holds the count at which the next timer interrupt is due. Software reaches both through a single register location. A read returns the live counter. A write loads the compare register, and the compare register cannot be read back.

When the low 32 bits of the counter equal the compare register, a sticky pending flag is set. The interrupt output shows that flag whenever the mask input is low. Software takes the interrupt by pulsing the acknowledge input or by writing a fresh compare value. The usual pattern is to read the counter, add the tick interval and write the sum back.

The counter can be 32 or 64 bits wide. Only its low 32 bits take part in the match. A compare value that the low bits have already passed therefore fires only after those bits wrap around. The register port and the interrupt pins are plain control signals. Data is never queued, so the port has no valid/ready handshake and no back-pressure.

Top module: `interval_timer`

## Requirements
- R1: After reset the counter reads zero, and it then increases by exactly one on every clock, whether or not the port is written.
- R2: `rd_data` always shows the current counter value. A write to the compare register never changes what `rd_data` shows.
- R3: The compare register is 32 bits wide for any counter width. A match needs only the low 32 bits of the counter to equal it. A value the low bits have already passed raises nothing until they wrap.
- R4: A match sets the pending flag on the following clock. The flag stays set until it is cleared.
- R5: An `irq_ack` pulse or a compare write clears the pending flag on the next clock, unless a match occurs in that same cycle.
- R6: `irq` is high exactly when the flag is pending and `irq_mask` is low. The flag latches even while masked, so a match that happens under the mask is delivered once the mask drops.
- R7: A written compare value is used from the next clock onward. A match in the cycle of the write is judged against the old compare value.
- R8: After reset the compare register holds all ones, the flag is clear and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; loads `wr_data` into the compare register |
| wr_data | input | 32 | Compare value to load |
| rd_data | output | CNT_W | Live counter value |
| irq_mask | input | 1 | High blocks `irq` without stopping the flag from latching |
| irq_ack | input | 1 | One-cycle pulse that clears the pending flag |
| irq | output | 1 | Timer interrupt request |

## Verification
Several compare values are tried: a value a short distance ahead of the counter, a value that the counter has just passed, and a value written in the very cycle that the old value matches. Together these separate correct next-cycle loading from immediate loading, and a low-32-bit match from a full-width match. Matches are also produced with the mask held high and then released, which shows whether the flag latches independently of the mask. A flag is cleared once by acknowledge and once by a rewrite, so each clearing path is confirmed on its own.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int CMP_W = 32;
  localparam logic [CMP_W-1:0] CMP_RESET = '1;
endpackage

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count
);
  import itmr_pkg::*;
  localparam int HI_W = CNT_W - CMP_W;

  logic [CMP_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else        lo_q <= lo_q + 1'b1;
  end

  generate
    if (HI_W > 0) begin : g_wide
      logic [HI_W-1:0] hi_q;
      logic            lo_wrap;
      assign lo_wrap = &lo_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_q <= '0;
        else if (lo_wrap) hi_q <= hi_q + 1'b1;
      end
      assign count = {hi_q, lo_q};
    end else begin : g_narrow
      assign count = lo_q;
    end
  endgenerate
endmodule

// File: rtl/itmr_compare.sv
module itmr_compare (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [itmr_pkg::CMP_W-1:0] load_val,
  input  logic [itmr_pkg::CMP_W-1:0] cnt_lo,
  output logic [itmr_pkg::CMP_W-1:0] cmp_val,
  output logic                   hit
);
  import itmr_pkg::*;

  logic [CMP_W-1:0] cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cmp_q <= CMP_RESET;
    else if (load) cmp_q <= load_val;
  end

  assign cmp_val = cmp_q;
  assign hit     = (cnt_lo == cmp_q);
endmodule

// File: rtl/itmr_pending.sv
module itmr_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ack,
  input  logic rewrite,
  input  logic mask,
  output logic pending,
  output logic req
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pend_q <= 1'b0;
    else if (hit)            pend_q <= 1'b1;
    else if (ack || rewrite) pend_q <= 1'b0;
  end

  assign pending = pend_q;
  assign req     = pend_q & ~mask;
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [CNT_W-1:0] rd_data,
  input  logic             irq_mask,
  input  logic             irq_ack,
  output logic             irq
);
  import itmr_pkg::*;

  logic [CNT_W-1:0] cnt_val;
  logic [CMP_W-1:0] cmp_val;
  logic             hit;
  logic             pend_val;

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .count (cnt_val)
  );

  itmr_compare u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_en),
    .load_val (wr_data),
    .cnt_lo   (cnt_val[CMP_W-1:0]),
    .cmp_val  (cmp_val),
    .hit      (hit)
  );

  itmr_pending u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .ack     (irq_ack),
    .rewrite (wr_en),
    .mask    (irq_mask),
    .pending (pend_val),
    .req     (irq)
  );

  assign rd_data = cnt_val;
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [CNT_W-1:0] rd_data,
  input logic             irq_mask,
  input logic             irq_ack,
  input logic             irq,
  input logic [31:0]      cmp,
  input logic             pending,
  input logic             hit
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rd_data == $past(rd_data) + {{(CNT_W-1){1'b0}}, 1'b1}); // R1
  AST_MATCH_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pending); // R4
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !irq_ack && !wr_en |=> pending); // R4
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !hit |=> !pending); // R5
  AST_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !hit |=> !pending); // R5
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (pending && !irq_mask)); // R6
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cmp == $past(wr_data)); // R7
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cmp)); // R7
  AST_MATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hit == (rd_data[31:0] == cmp)); // R3
endmodule

bind interval_timer interval_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .irq_mask (irq_mask),
  .irq_ack  (irq_ack),
  .irq      (irq),
  .cmp      (cmp_val),
  .pending  (pend_val),
  .hit      (hit)
);

// File: tb/interval_timer_test.sv
`timescale 1ns/1ps
module interval_timer_test;
  localparam int CNT_W = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [31:0]      wr_data = '0;
  logic [CNT_W-1:0] rd_data;
  logic             irq_mask = 1'b0;
  logic             irq_ack = 1'b0;
  logic             irq;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  longint unsigned m_cnt = 0;
  int unsigned     m_cmp = 32'hFFFF_FFFF;
  bit              m_pend = 1'b0;

  always #4 clk = ~clk;

  interval_timer #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_mask(irq_mask), .irq_ack(irq_ack), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every active edge
  always @(posedge clk) begin
    if (rst_n) begin
      bit match;
      match = (m_cnt[31:0] == m_cmp);
      if (match)                  m_pend = 1'b1;
      else if (wr_en || irq_ack)  m_pend = 1'b0;
      if (wr_en) m_cmp = wr_data;
      m_cnt = m_cnt + 1;
    end
  end

  // compare against the reference every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rd_data == m_cnt, "R1 R2 counter", rd_data, m_cnt);
      chk(irq == (m_pend && !irq_mask), "R4 R6 irq", irq, m_pend && !irq_mask);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [31:0] v);
    wr_data = v;
    wr_en = 1'b1;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    cyc(1);
    irq_ack = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] a;
    logic [31:0] b;
    cyc(3);
    chk(rd_data == 0, "R8 counter held in reset", rd_data, 0);
    chk(irq == 1'b0, "R8 irq low in reset", irq, 0);
    rst_n = 1'b1;
    cyc(5);
    chk(rd_data == 5, "R1 count after five clocks", rd_data, 5);
    chk(irq == 1'b0, "R8 no irq with all-ones compare", irq, 0);

    // simple match ahead of the counter
    a = m_cnt[31:0] + 20;
    wr(a);
    chk(rd_data == m_cnt, "R2 write leaves read value", rd_data, m_cnt);
    cyc(25);
    chk(irq == 1'b1, "R4 irq after match", irq, 1);
    cyc(10);
    chk(irq == 1'b1, "R4 flag sticky", irq, 1);
    ack();
    chk(irq == 1'b0, "R5 ack clears", irq, 0);

    // match under mask, delivered after unmask
    irq_mask = 1'b1;
    wr(m_cnt[31:0] + 10);
    cyc(15);
    chk(irq == 1'b0, "R6 masked irq low", irq, 0);
    irq_mask = 1'b0;
    cyc(1);
    chk(irq == 1'b1, "R6 latched match delivered on unmask", irq, 1);

    // rewrite clears pending flag
    wr(m_cnt[31:0] + 5000);
    chk(irq == 1'b0, "R5 write clears", irq, 0);

    // value already passed: no interrupt within a long window
    wr(m_cnt[31:0] - 5);
    cyc(2000);
    chk(irq == 1'b0, "R3 passed value does not fire", irq, 0);

    // write in the cycle the old value matches
    a = m_cnt[31:0] + 30;
    wr(a);
    while (m_cnt[31:0] != a) cyc(1);
    b = a + 40;
    wr(b);
    chk(irq == 1'b1, "R7 old compare matches in write cycle", irq, 1);
    ack();
    chk(irq == 1'b0, "R5 ack after same-cycle match", irq, 0);
    while (m_cnt[31:0] != b) cyc(1);
    chk(irq == 1'b0, "R7 new value not yet matched", irq, 0);
    cyc(1);
    chk(irq == 1'b1, "R7 new compare used", irq, 1);

    // compare equal to next count: fires one clock after loading
    ack();
    wr(m_cnt[31:0] + 1);
    chk(irq == 1'b0, "R7 not before load takes effect", irq, 0);
    cyc(1);
    chk(irq == 1'b1, "R7 fires right after load", irq, 1);
    ack();
    cyc(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule